// File: doc/BRIEF.md
# Recognition Confidence Gate with Retrain Capture

This block sits after a bank of small classifier networks that each score one image region. For every region the networks' confidence scores arrive as a short stream of beats, each beat naming the network that produced it; the beat marked as last closes the region. The block keeps the strongest score seen so far. When the region closes, it places that score in one of three bands set by two programmable limits. A high score is accepted as a valid recognition. A middling score raises a retraining request. A low score is rejected as no-valid.

A retraining request also captures learning material. The small pixel vector presented with the closing beat is written, as one word, into the training-pattern memory of the network that won the region. Each network's memory has its own fill pointer and full flag. A request that finds the winner's memory full still reports the request, but the pattern is discarded and a saturating drop counter is advanced. The retraining algorithm itself lives elsewhere.

Top module: `conf_retrain_gate`

## Requirements
- R1: While reset is held and after it is released, dec_vld, dec_accept, dec_reconf and mem_we are 0, every net_full bit is 0 and drop_cnt is 0.
- R2: A beat with conf_vld=1 and conf_last=1 closes a region; dec_vld is 1 on the clock cycle after that edge only, and is 0 in every cycle that does not follow a closing beat.
- R3: The region winner is the beat with the largest conf_val among all beats since the previous closing beat, the closing beat included; on equal values the smaller conf_net wins, whatever the arrival order; dec_net reports the winner.
- R4: If the winning confidence is strictly greater than thr_hi, the decision has dec_accept=1 and dec_reconf=0.
- R5: If the winning confidence is greater than thr_lo and less than or equal to thr_hi, the decision has dec_reconf=1 and dec_accept=0; a value equal to thr_hi falls in this band.
- R6: If the winning confidence is less than or equal to thr_lo, the decision has dec_accept=0 and dec_reconf=0, and nothing is written.
- R7: A request whose winner memory is not full gives mem_we=1 in the same cycle as dec_vld, with mem_sel equal to the winner and mem_wdata equal to feat_vec as sampled with the closing beat; mem_we is 0 otherwise.
- R8: Each network has its own fill count starting at 0; mem_addr is the winner's count before the write, the count rises by one per stored pattern, and net_full bit n is 1 once network n holds MEM_DEPTH patterns.
- R9: A request whose winner memory is full writes nothing and raises drop_cnt by one, saturating at its all-ones value; dec_reconf is still 1 for that decision.
- R10: thr_lo and thr_hi are taken as applied on the closing beat; changing them between regions changes the band of the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conf_vld | input | 1 | Confidence beat present |
| conf_last | input | 1 | Beat closes the current region |
| conf_net | input | IDX_W | Network that produced the beat |
| conf_val | input | 8 | Confidence, 255 = full certainty |
| feat_vec | input | FEAT_ELEMS*PIX_W | Region pixel vector, sampled with the closing beat |
| thr_lo | input | 8 | Upper limit of the reject band |
| thr_hi | input | 8 | Upper limit of the retrain band |
| dec_vld | output | 1 | Decision present |
| dec_accept | output | 1 | Valid recognition |
| dec_reconf | output | 1 | Retraining request |
| dec_net | output | IDX_W | Winning network |
| mem_we | output | 1 | Training-pattern write strobe |
| mem_sel | output | IDX_W | Memory (network) written |
| mem_addr | output | AW | Slot written |
| mem_wdata | output | FEAT_ELEMS*PIX_W | Pattern written |
| net_full | output | NUM_NETS | Per-network memory full |
| drop_cnt | output | DROP_W | Saturating count of discarded patterns |

## Verification
Single-beat regions whose scores sit one step either side of each limit, and exactly on both limits, tell the three bands apart and pin down the closed and open ends. Multi-beat regions where the strongest score arrives last, or where equal scores come in descending index order, separate a true maximum with index tie-break from a first-seen or last-seen choice. Repeated middle-band requests to one network, with requests to another in between, show that fill counts are independent, that the slot address advances, that a full memory drops instead of overwriting, and that the drop counter stops at its ceiling.

// File: rtl/conf_pkg.sv
package conf_pkg;

    localparam int CONF_W = 8;

    typedef logic [CONF_W-1:0] conf_t;

    typedef enum logic [1:0] {
        BAND_REJECT  = 2'd0,
        BAND_RETRAIN = 2'd1,
        BAND_ACCEPT  = 2'd2
    } band_e;

    typedef struct packed {
        logic vld;
        logic accept;
        logic reconf;
    } verdict_t;

    // Upper limit of each band is inclusive.
    function automatic band_e classify(input conf_t c, input conf_t lo, input conf_t hi);
        if (c > hi)
            return BAND_ACCEPT;
        else if (c > lo)
            return BAND_RETRAIN;
        else
            return BAND_REJECT;
    endfunction

endpackage

// File: rtl/conf_tracker.sv
module conf_tracker
    import conf_pkg::*;
#(
    parameter int NUM_NETS = 3,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_vld,
    input  logic             beat_last,
    input  logic [IDX_W-1:0] beat_idx,
    input  conf_t            beat_conf,
    output logic [IDX_W-1:0] win_idx,
    output conf_t            win_conf
);

    logic             seen_q;
    conf_t            best_q;
    logic [IDX_W-1:0] idx_q;
    logic             take;

    always_comb begin
        take = !seen_q
            || (beat_conf > best_q)
            || ((beat_conf == best_q) && (beat_idx < idx_q));
        if (beat_vld && take) begin
            win_idx  = beat_idx;
            win_conf = beat_conf;
        end else begin
            win_idx  = idx_q;
            win_conf = best_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            best_q <= '0;
            idx_q  <= '0;
        end else if (beat_vld) begin
            if (beat_last) begin
                seen_q <= 1'b0;
            end else begin
                seen_q <= 1'b1;
                best_q <= win_conf;
                idx_q  <= win_idx;
            end
        end
    end

    // R3
    best_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && !beat_last && seen_q) |=> (best_q >= $past(best_q)));

endmodule

// File: rtl/pattern_capture.sv
module pattern_capture #(
    parameter int NUM_NETS = 3,
    parameter int IDX_W    = 2,
    parameter int DEPTH    = 4,
    parameter int AW       = 2,
    parameter int CNT_W    = 3,
    parameter int DATA_W   = 240,
    parameter int DROP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_data,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_sel,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NUM_NETS-1:0] full_o,
    output logic [DROP_W-1:0] drop_cnt
);

    localparam logic [IDX_W:0] NET_LIMIT = (IDX_W+1)'(NUM_NETS);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q [NUM_NETS];
    logic             idx_ok;
    logic             sel_full;
    logic [CNT_W-1:0] sel_cnt;
    logic             store;

    always_comb begin
        idx_ok   = ({1'b0, req_idx} < NET_LIMIT);
        sel_full = 1'b1;
        sel_cnt  = '0;
        for (int n = 0; n < NUM_NETS; n++) begin
            if (req_idx == IDX_W'(n)) begin
                sel_full = full_o[n];
                sel_cnt  = cnt_q[n];
            end
        end
        store = req && idx_ok && !sel_full;
    end

    for (genvar g = 0; g < NUM_NETS; g++) begin : g_net
        assign full_o[g] = (cnt_q[g] == CNT_FULL);

        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (store && (req_idx == IDX_W'(g)))
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end

        // R8
        full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            full_o[g] |=> full_o[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_sel   <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            drop_cnt  <= '0;
        end else begin
            mem_we <= store;
            if (store) begin
                mem_sel   <= req_idx;
                mem_addr  <= sel_cnt[AW-1:0];
                mem_wdata <= req_data;
            end
            if (req && !store && (drop_cnt != '1))
                drop_cnt <= drop_cnt + 1'b1;
        end
    end

    // R7
    write_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(req));

    // R9
    drop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));

    // R9
    drop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req && sel_full) |=> !mem_we);

endmodule

// File: rtl/conf_retrain_gate.sv
module conf_retrain_gate
    import conf_pkg::*;
#(
    parameter int NUM_NETS   = 3,
    parameter int FEAT_ELEMS = 30,
    parameter int PIX_W      = 8,
    parameter int MEM_DEPTH  = 4,
    parameter int DROP_W     = 8,
    localparam int IDX_W     = (NUM_NETS > 1) ? $clog2(NUM_NETS) : 1,
    localparam int FEAT_W    = FEAT_ELEMS * PIX_W,
    localparam int AW        = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
    localparam int CNT_W     = $clog2(MEM_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conf_vld,
    input  logic                conf_last,
    input  logic [IDX_W-1:0]    conf_net,
    input  logic [7:0]          conf_val,
    input  logic [FEAT_W-1:0]   feat_vec,
    input  logic [7:0]          thr_lo,
    input  logic [7:0]          thr_hi,
    output logic                dec_vld,
    output logic                dec_accept,
    output logic                dec_reconf,
    output logic [IDX_W-1:0]    dec_net,
    output logic                mem_we,
    output logic [IDX_W-1:0]    mem_sel,
    output logic [AW-1:0]       mem_addr,
    output logic [FEAT_W-1:0]   mem_wdata,
    output logic [NUM_NETS-1:0] net_full,
    output logic [DROP_W-1:0]   drop_cnt
);

    logic [IDX_W-1:0] win_idx;
    conf_t            win_conf;
    logic             closing;
    band_e            band;
    verdict_t         verdict_q;
    logic [IDX_W-1:0] net_q;

    conf_tracker #(
        .NUM_NETS (NUM_NETS),
        .IDX_W    (IDX_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .beat_vld  (conf_vld),
        .beat_last (conf_last),
        .beat_idx  (conf_net),
        .beat_conf (conf_val),
        .win_idx   (win_idx),
        .win_conf  (win_conf)
    );

    assign closing = conf_vld && conf_last;
    assign band    = classify(win_conf, thr_lo, thr_hi);

    pattern_capture #(
        .NUM_NETS (NUM_NETS),
        .IDX_W    (IDX_W),
        .DEPTH    (MEM_DEPTH),
        .AW       (AW),
        .CNT_W    (CNT_W),
        .DATA_W   (FEAT_W),
        .DROP_W   (DROP_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .req       (closing && (band == BAND_RETRAIN)),
        .req_idx   (win_idx),
        .req_data  (feat_vec),
        .mem_we    (mem_we),
        .mem_sel   (mem_sel),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .full_o    (net_full),
        .drop_cnt  (drop_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
            net_q     <= '0;
        end else begin
            verdict_q.vld    <= closing;
            verdict_q.accept <= closing && (band == BAND_ACCEPT);
            verdict_q.reconf <= closing && (band == BAND_RETRAIN);
            if (closing)
                net_q <= win_idx;
        end
    end

    assign dec_vld    = verdict_q.vld;
    assign dec_accept = verdict_q.accept;
    assign dec_reconf = verdict_q.reconf;
    assign dec_net    = net_q;

    // R2
    decision_follows_close_chk: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> $past(conf_vld && conf_last));

    // R4
    accept_has_decision_chk: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> (dec_vld && !dec_reconf));

    // R7
    write_is_request_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (dec_reconf && (mem_sel == dec_net)));

endmodule

// File: tb/conf_retrain_gate_tb.sv
module conf_retrain_gate_tb;

    localparam int NUM_NETS = 3;
    localparam int DEPTH    = 4;
    localparam int IDX_W    = 2;
    localparam int FEAT_W   = 240;
    localparam int AW       = 2;
    localparam int DROP_W   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conf_vld = 1'b0, conf_last = 1'b0;
    logic [IDX_W-1:0] conf_net = '0;
    logic [7:0] conf_val = '0;
    logic [FEAT_W-1:0] feat_vec = '0;
    logic [7:0] thr_lo = 8'd127, thr_hi = 8'd191;

    logic dec_vld, dec_accept, dec_reconf, mem_we;
    logic [IDX_W-1:0] dec_net, mem_sel;
    logic [AW-1:0] mem_addr;
    logic [FEAT_W-1:0] mem_wdata;
    logic [NUM_NETS-1:0] net_full;
    logic [DROP_W-1:0] drop_cnt;

    always #5 clk = ~clk;

    conf_retrain_gate u_dut (
        .clk(clk), .rst(rst), .conf_vld(conf_vld), .conf_last(conf_last),
        .conf_net(conf_net), .conf_val(conf_val), .feat_vec(feat_vec),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .dec_vld(dec_vld),
        .dec_accept(dec_accept), .dec_reconf(dec_reconf), .dec_net(dec_net),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .net_full(net_full), .drop_cnt(drop_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    // Behavioural reference model state
    bit m_seen;
    int m_val, m_idx;
    int m_cnt [NUM_NETS];
    int m_drops;
    bit e_vld, e_acc, e_rec, e_we;
    int e_net, e_sel, e_addr;
    logic [FEAT_W-1:0] e_data;

    always @(posedge clk) begin
        if (rst) begin
            m_seen = 0; m_val = 0; m_idx = 0; m_drops = 0;
            for (int n = 0; n < NUM_NETS; n++) m_cnt[n] = 0;
            e_vld = 0; e_acc = 0; e_rec = 0; e_we = 0;
        end else begin
            e_vld = 0; e_acc = 0; e_rec = 0; e_we = 0;
            if (conf_vld) begin
                if (!m_seen || int'(conf_val) > m_val ||
                    (int'(conf_val) == m_val && int'(conf_net) < m_idx)) begin
                    m_val = int'(conf_val);
                    m_idx = int'(conf_net);
                end
                m_seen = 1;
                if (conf_last) begin
                    e_vld = 1;
                    e_net = m_idx;
                    if (m_val > int'(thr_hi)) e_acc = 1;
                    else if (m_val > int'(thr_lo)) begin
                        e_rec = 1;
                        if (m_cnt[m_idx] < DEPTH) begin
                            e_we = 1; e_sel = m_idx; e_addr = m_cnt[m_idx];
                            e_data = feat_vec;
                            m_cnt[m_idx]++;
                        end else if (m_drops < 255) m_drops++;
                    end
                    m_seen = 0;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2", "dec_vld", dec_vld, e_vld);
            chk("R4", "dec_accept", dec_accept, e_acc);
            chk("R5", "dec_reconf", dec_reconf, e_rec);
            if (e_vld) chk("R3", "dec_net", dec_net, e_net);
            chk("R7", "mem_we", mem_we, e_we);
            if (e_we) begin
                chk("R7", "mem_sel", mem_sel, e_sel);
                chk("R8", "mem_addr", mem_addr, e_addr);
                n_chk++;
                if (mem_wdata !== e_data) begin
                    n_bad++;
                    $display("FAIL R7 mem_wdata: actual %h expected %h", mem_wdata, e_data);
                end
            end
            for (int n = 0; n < NUM_NETS; n++)
                chk("R8", "net_full", net_full[n], m_cnt[n] == DEPTH);
            chk("R9", "drop_cnt", drop_cnt, m_drops);
        end
    end

    task automatic beat(input int idx, input int val, input bit last);
        @(negedge clk);
        conf_vld  = 1'b1;
        conf_last = last;
        conf_net  = IDX_W'(idx);
        conf_val  = 8'(val);
        feat_vec  = {8{$urandom}};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            conf_vld = 1'b0; conf_last = 1'b0;
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state seen at the ports
        chk("R1", "reset dec_vld", dec_vld, 0);
        chk("R1", "reset mem_we", mem_we, 0);
        chk("R1", "reset full", net_full, 0);
        chk("R1", "reset drops", drop_cnt, 0);

        beat(0, 230, 1);                       // R4 accept
        beat(2, 100, 0); beat(0, 100, 0); beat(1, 99, 1); // R3 tie -> 0, R6 reject
        beat(0, 50, 0); beat(2, 240, 0); beat(1, 200, 1); // R3 max arrives mid
        beat(1, 191, 1);                       // R5 exactly upper limit -> request
        beat(2, 127, 1);                       // R6 exactly lower limit -> reject
        beat(2, 128, 1);                       // R5 just above lower limit
        beat(1, 192, 1);                       // R4 just above upper limit
        idle(2);
        beat(1, 150, 1); beat(0, 140, 1); beat(1, 150, 1); // R8 independent counts
        beat(1, 150, 1);                       // R8 net 1 full
        beat(1, 150, 1);                       // R9 dropped
        idle(1);
        thr_hi = 8'd100;                       // R10 new limit
        beat(1, 150, 1);
        beat(0, 90, 1);
        thr_hi = 8'd191;
        for (int i = 0; i < 260; i++) beat(1, 160, 1); // R9 saturation
        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule